// File: doc/BRIEF.md
# Cache Line Burst Address Sequencer

This block sits on the memory side of a processor bus with a 64-bit data path. The requester opens a transfer by pulling a strobe low for one clock. With the strobe it presents a quadword address, a read/write flag, per-byte lane enables and an active-low line request. The sequencer answers with an active-low transfer-done pulse for every quadword it moves. It also drives an active-low fill-accept signal that tells the requester the access has become a full 32-byte line transfer.

A line transfer happens when the requester asks for a line and the addressed line lies in the cacheable part of the map, which is lines below the parameter `NC_BASE`. The requester drives only the first quadword address. The sequencer derives the other three itself by XOR-ing the first quadword offset with a beat counter that runs 0, 1, 2, 3. This gives an order that suits two-way interleaved storage. Read and write line transfers both run this way. Any other access is a single one-quadword transfer that honours the byte lanes. The storage is a small internal array of `LINES` lines of four quadwords.

The controller has three states. IDLE waits for the strobe. SINGLE moves one quadword. FILL moves four quadwords. The transitions are:
- IDLE to FILL: strobe low with a line request to a cacheable line.
- IDLE to SINGLE: strobe low on any other access.
- SINGLE to IDLE: always.
- FILL to FILL: while the beat counter is below 3.
- FILL to IDLE: after the fourth beat.

Top module: `burst_seq`

## Requirements
- R1: After reset, `xfer_done_n` and `fill_ok_n` are 1 and `rd_data` is 0.
- R2: A single transfer is one of two kinds: a strobe with `line_req_n` = 1, or any access to line `NC_BASE` or above. It gives exactly one clock of `xfer_done_n` = 0, in the clock after the strobe is sampled, and `fill_ok_n` stays 1.
- R3: A strobe with `line_req_n` = 0 to a line below `NC_BASE` gives four consecutive clocks of `xfer_done_n` = 0, the first one in the clock after the strobe. `fill_ok_n` is 0 in exactly those four clocks (a 2-1-1-1 pattern).
- R4: Beat k of a line transfer uses the quadword offset (first offset XOR k). The offset is `qw_addr[1:0]`, which is byte-address bits 4..3. Start 0 gives 0,1,2,3; start 1 gives 1,0,3,2; start 2 gives 2,3,0,1; start 3 gives 3,2,1,0.
- R5: In a write line transfer, the `wr_data` present in beat k is stored at offset (first XOR k), in all eight byte lanes, whatever `lane_en` holds.
- R6: A single write stores only the bytes whose `lane_en` bit i is 1. Bit i selects `wr_data[8i+7:8i]`. The other bytes keep their old value.
- R7: A strobe seen while a transfer is in progress is ignored. The running burst keeps its address and beat count, and no extra beat follows it.
- R8: Reads return the stored quadword on `rd_data` in each clock where `xfer_done_n` = 0. In all other clocks `rd_data` is 0.
- R9: A strobe sampled in the first clock after the last beat is accepted, so transfers can run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_n | input | 1 | Transfer start, active low, sampled in IDLE only |
| qw_addr | input | 6 | Quadword address: line in [5:2], offset in [1:0] |
| is_write | input | 1 | 1 = write, 0 = read |
| line_req_n | input | 1 | Requester asks for a whole line, active low |
| lane_en | input | 8 | Byte lane enables for single writes |
| wr_data | input | 64 | Write data, one quadword per beat |
| rd_data | output | 64 | Read data, valid while xfer_done_n is 0 |
| xfer_done_n | output | 1 | One quadword moved this clock, active low |
| fill_ok_n | output | 1 | Access runs as a line transfer, active low |

## Verification
The assertions assume a few things about the requester. It never holds the strobe across a reset. It presents address, direction, lanes and line request in the same clock as the strobe. It supplies write data in every beat clock. The stimulus meets these by driving every input on the falling edge, opening each transfer with a one-clock strobe, and pulling the strobe low during a burst only in the test that checks it is ignored.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_FILL   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/burst_seq_order.sv
module burst_seq_order #(
    parameter int BEATS = 4,
    localparam int OFF_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [OFF_W-1:0] first_off,
    output logic [OFF_W-1:0] beat_off,
    output logic             last_beat
);
    logic [OFF_W-1:0] base_q;
    logic [OFF_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= first_off;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // interleave order: start offset XOR running beat count
    assign beat_off  = base_q ^ cnt_q;
    assign last_beat = (cnt_q == OFF_W'(BEATS - 1));

    // R4: consecutive beats alternate the low offset bit
    p_lsb_alternates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last_beat && !load) |=> (beat_off[0] != $past(beat_off[0])));
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_n,
    input  logic       line_req_n,
    input  logic       line_cacheable,
    input  logic       last_beat,
    output seq_state_e state,
    output logic       load,
    output logic       step,
    output logic       xfer_done_n,
    output logic       fill_ok_n
);
    seq_state_e state_q, state_d;

    assign load = (state_q == ST_IDLE) && !strobe_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    if (!line_req_n && line_cacheable) state_d = ST_FILL;
                    else                               state_d = ST_SINGLE;
                end
            end
            ST_SINGLE: state_d = ST_IDLE;
            ST_FILL:   state_d = last_beat ? ST_IDLE : ST_FILL;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        xfer_done_n = 1'b1;
        fill_ok_n   = 1'b1;
        step        = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SINGLE: xfer_done_n = 1'b0;
            ST_FILL: begin
                xfer_done_n = 1'b0;
                fill_ok_n   = 1'b0;
                step        = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;

    // R2: a single beat is followed by a quiet clock
    p_single_one_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_done_n && fill_ok_n) |=> xfer_done_n);
    // R3: fill accept only accompanies a beat
    p_fill_with_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_ok_n |-> !xfer_done_n);
    // R3: a line transfer, once started, continues into a second beat
    p_fill_continues_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fill_ok_n) |=> (!xfer_done_n && !fill_ok_n));
    // R7: the strobe cannot cut a burst short or restart it
    p_burst_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && !last_beat) |=> (state_q == ST_FILL));
endmodule

// File: rtl/burst_seq_mem.sv
module burst_seq_mem #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 6,
    localparam int LANES = DATA_W / 8,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] idx,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < LANES; b++) begin
                if (lanes[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int LINES   = 16,
    parameter int BEATS   = 4,
    parameter int NC_BASE = 12,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BEATS),
    localparam int LINE_W = $clog2(LINES),
    localparam int QAW    = LINE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [QAW-1:0]    qw_addr,
    input  logic              is_write,
    input  logic              line_req_n,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              xfer_done_n,
    output logic              fill_ok_n
);
    seq_state_e        state;
    logic              load, step, last_beat, cacheable;
    logic [OFF_W-1:0]  beat_off;
    logic [LINE_W-1:0] line_q;
    logic              wr_q;
    logic [LANES-1:0]  lanes_q;
    logic [DATA_W-1:0] mem_rdata;
    logic [LANES-1:0]  mem_lanes;
    logic              mem_we;

    assign cacheable = ({1'b0, qw_addr[QAW-1:OFF_W]} < (LINE_W + 1)'(NC_BASE));

    burst_seq_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe_n       (strobe_n),
        .line_req_n     (line_req_n),
        .line_cacheable (cacheable),
        .last_beat      (last_beat),
        .state          (state),
        .load           (load),
        .step           (step),
        .xfer_done_n    (xfer_done_n),
        .fill_ok_n      (fill_ok_n)
    );

    burst_seq_order #(.BEATS(BEATS)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .first_off (qw_addr[OFF_W-1:0]),
        .beat_off  (beat_off),
        .last_beat (last_beat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            wr_q    <= 1'b0;
            lanes_q <= '0;
        end else if (load) begin
            line_q  <= qw_addr[QAW-1:OFF_W];
            wr_q    <= is_write;
            lanes_q <= lane_en;
        end
    end

    // line transfers always move whole quadwords
    assign mem_lanes = (state == ST_FILL) ? '1 : lanes_q;
    assign mem_we    = !xfer_done_n && wr_q;

    burst_seq_mem #(.DATA_W(DATA_W), .ADDR_W(QAW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .idx   ({line_q, beat_off}),
        .lanes (mem_lanes),
        .wdata (wr_data),
        .rdata (mem_rdata)
    );

    assign rd_data = (!xfer_done_n && !wr_q) ? mem_rdata : '0;

    // R7: captured line stays fixed for the rest of a burst
    p_line_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last_beat) |=> $stable(line_q));
    // R8: read data is quiet outside beats
    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_n |-> (rd_data == '0));
    // R1: nothing moves in the clock after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (xfer_done_n && fill_ok_n));
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_n = 1'b1;
    logic [5:0]  qw_addr = '0;
    logic        is_write = 1'b0;
    logic        line_req_n = 1'b1;
    logic [7:0]  lane_en = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        xfer_done_n, fill_ok_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    logic [63:0] model [64];

    always #2 clk = ~clk;

    burst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .qw_addr(qw_addr),
        .is_write(is_write), .line_req_n(line_req_n), .lane_en(lane_en),
        .wr_data(wr_data), .rd_data(rd_data), .xfer_done_n(xfer_done_n),
        .fill_ok_n(fill_ok_n)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d, input logic [7:0] be);
        logic [63:0] m = old;
        for (int i = 0; i < 8; i++) if (be[i]) m[8*i +: 8] = d[8*i +: 8];
        return m;
    endfunction

    // called at a falling edge; returns at the falling edge after the last beat
    task automatic xfer(input int line, input int off, input bit wr, input bit req_n,
                        input logic [7:0] be, input logic [63:0] seed, input bit ign, input string tag);
        int nb = (!req_n && line < 12) ? 4 : 1;
        strobe_n = 1'b0; qw_addr = 6'(line * 4 + off); is_write = wr;
        line_req_n = req_n; lane_en = be;
        @(negedge clk);
        strobe_n = 1'b1;
        for (int k = 0; k < nb; k++) begin
            int idx = line * 4 + (off ^ k);
            chk(xfer_done_n == 1'b0, {tag, " beat present"}, 64'(xfer_done_n), 64'd0);
            chk(fill_ok_n == (nb == 4 ? 1'b0 : 1'b1), {tag, " fill accept"}, 64'(fill_ok_n), 64'(nb != 4));
            if (wr) begin
                wr_data = seed + 64'(k);
                model[idx] = (nb == 4) ? wr_data : merge(model[idx], wr_data, be);
            end else begin
                chk(rd_data === model[idx], {tag, " read data order"}, rd_data, model[idx]);
            end
            if (ign && k == 1) begin
                strobe_n = 1'b0; qw_addr = 6'(((line + 1) % 12) * 4); line_req_n = 1'b0; is_write = ~wr;
            end
            if (ign && k == 2) begin
                strobe_n = 1'b1; qw_addr = 6'(line * 4 + off); is_write = wr;
            end
            @(negedge clk);
        end
        chk(xfer_done_n == 1'b1, {tag, " no extra beat"}, 64'(xfer_done_n), 64'd1);
        chk(rd_data == 64'd0, "R8 idle read data zero", rd_data, 64'd0);
    endtask

    task automatic t_reset();
        chk(xfer_done_n == 1'b1 && fill_ok_n == 1'b1, "R1 reset outputs", {62'd0, xfer_done_n, fill_ok_n}, 64'd3);
        chk(rd_data == 64'd0, "R1 reset rdata", rd_data, 64'd0);
    endtask

    task automatic t_fill_write_init();
        for (int l = 0; l < 12; l++)
            xfer(l, l % 4, 1'b1, 1'b0, 8'h00, 64'hC0DE_0000_0000_0000 | (64'(l) << 8), 1'b0, "R5 write line");
    endtask

    task automatic t_noncache();
        for (int l = 12; l < 16; l++)
            for (int o = 0; o < 4; o++)
                xfer(l, o, 1'b1, 1'b0, 8'hFF, 64'hBEEF_0000_0000_0000 | 64'(l * 16 + o), 1'b0, "R2 noncacheable write");
        xfer(13, 2, 1'b0, 1'b0, 8'hFF, 64'd0, 1'b0, "R2 noncacheable read");
    endtask

    task automatic t_orders();
        for (int o = 0; o < 4; o++) xfer(3, o, 1'b0, 1'b0, 8'hFF, 64'd0, 1'b0, "R4 read order");
        for (int o = 0; o < 4; o++) xfer(7, o, 1'b0, 1'b0, 8'hFF, 64'd0, 1'b0, "R3 read line");
        // R5: data written from offset 2 lands in 2,3,0,1 order
        xfer(9, 2, 1'b1, 1'b0, 8'h01, 64'h5150_0000_0000_0090, 1'b0, "R5 lanes ignored");
        for (int o = 0; o < 4; o++) xfer(9, o, 1'b0, 1'b1, 8'hFF, 64'd0, 1'b0, "R5 readback");
    endtask

    task automatic t_single();
        xfer(5, 1, 1'b0, 1'b1, 8'hFF, 64'd0, 1'b0, "R2 single read");
        xfer(6, 2, 1'b1, 1'b1, 8'h5A, 64'h1122_3344_5566_7788, 1'b0, "R6 lane write");
        xfer(6, 2, 1'b0, 1'b1, 8'hFF, 64'd0, 1'b0, "R6 lane readback");
        xfer(14, 0, 1'b1, 1'b1, 8'h81, 64'hAA00_0000_0000_00BB, 1'b0, "R6 edge lanes");
        xfer(14, 0, 1'b0, 1'b1, 8'h00, 64'd0, 1'b0, "R6 edge readback");
    endtask

    task automatic t_busy_ignore();
        xfer(2, 3, 1'b0, 1'b0, 8'hFF, 64'd0, 1'b1, "R7 strobe during read burst");
        xfer(4, 1, 1'b1, 1'b0, 8'hFF, 64'h7700_0000_0000_0000, 1'b1, "R7 strobe during write burst");
        xfer(4, 1, 1'b0, 1'b0, 8'hFF, 64'd0, 1'b0, "R7 readback");
        xfer(5, 0, 1'b0, 1'b0, 8'hFF, 64'd0, 1'b0, "R7 neighbour untouched");
    endtask

    task automatic t_back_to_back();
        xfer(10, 1, 1'b0, 1'b0, 8'hFF, 64'd0, 1'b0, "R9 first");
        xfer(11, 3, 1'b0, 1'b0, 8'hFF, 64'd0, 1'b0, "R9 second");
        xfer(0, 0, 1'b0, 1'b1, 8'hFF, 64'd0, 1'b0, "R9 third single");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 'x;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_write_init();
        t_noncache();
        t_orders();
        t_single();
        t_busy_ignore();
        t_back_to_back();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule